// File: doc/BRIEF.md
# Grouped Interrupt Aggregator

This block gathers interrupt sources from four peripheral groups and turns them into a single host interrupt line. Each source is first brought into the clock domain through a synchroniser. Each group then has its own bank of per-bit controls: a detection style (edge or level), a high-side and a low-side polarity enable, a mask set through separate set and clear registers, and a sticky pending bit that software acknowledges by writing a one.

The register port takes 16-bit addresses and 8-bit data. Writes take effect in one cycle and reads are registered. A summary register gives one bit per group, and that bit is set when the group holds a pending interrupt that is also enabled. The host line is the registered OR of those summary bits. Group 0 carries five sources in bits 0 to 4. Groups 1 to 3 carry one source each, in bit 0. The `src_i` bus packs them as group 0 in bits 4:0, then group 1 in bit 5, group 2 in bit 6 and group 3 in bit 7.

Top module: `irq_agg`

## Requirements
- R1: After a synchronous reset, every register reads 0 and `irq_o` is 0. All sources are then masked, level-sensitive and have no polarity selected.
- R2: The group bases are 0x0900, 0x2400, 0xC000 and 0xC100, and the register offsets from a base are: raw 0x10, mode 0x11, pol-high 0x12, pol-low 0x13, ack 0x14, mask-set 0x15, mask-clear 0x16, pending 0x18. An unmapped address or offset reads 0. Bits that have no source read 0 and ignore writes.
- R3: The raw register returns the synchronised input level of each source, whatever its mask and polarity settings.
- R4: Writing 1 to a mask-set bit enables that source, and writing 1 to a mask-clear bit disables it. Writing 0 leaves the bit unchanged. Reads at 0x15 and at 0x16 both return the current enable bits.
- R5: Mode bit 1 with pol-high only: a rising edge latches the pending bit and a falling edge does not.
- R6: Mode bit 1 with pol-low only: a falling edge latches the pending bit and a rising edge does not.
- R7: Mode bit 1 with both polarities set: both edges latch the pending bit.
- R8: Mode bit 0 is level mode. The pending bit latches while the input is at its active level (high with pol-high, low with pol-low). If the input is still active after an acknowledge, the bit latches again on the next cycle.
- R9: A masked source never sets its pending bit.
- R10: Writing 1 to an ack bit clears that pending bit on the write edge. Writing 0 leaves it unchanged.
- R11: Bit g of the summary register at 0x0550 is 1 exactly when group g has a pending bit whose enable is also set. Masking a pending bit hides it from the summary but keeps it pending.
- R12: `irq_o` is the registered OR of the summary bits. After an input change, the pending bit is set on the third clock edge and `irq_o` rises on the fourth.
- R13: `rdata_o` loads on the edge that samples `rd_i` and holds its value while no read is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 8 | Raw interrupt sources, group 0 in bits 4:0, groups 1..3 in bits 5..7 |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 16 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| irq_o | output | 1 | Combined host interrupt, registered |

## Verification
After an input change, the raw value becomes visible after the second edge, the pending bit is set on the third edge and `irq_o` rises on the fourth. A register write takes effect on its own edge, and read data reflects the state just before the edge that samples the read. The table-driven part therefore waits five edges after every input change before it reads anything, and it inserts idle cycles before reads that follow a re-latch or an enable. The directed tests sample `irq_o` exactly on the third and fourth edges to check the latency, and sample it on the single-cycle gap that a level re-latch leaves after an acknowledge.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  // Register offsets inside one group page.
  localparam logic [7:0] OFF_RAW  = 8'h10;
  localparam logic [7:0] OFF_MODE = 8'h11;
  localparam logic [7:0] OFF_POLH = 8'h12;
  localparam logic [7:0] OFF_POLL = 8'h13;
  localparam logic [7:0] OFF_ACK  = 8'h14;
  localparam logic [7:0] OFF_MSET = 8'h15;
  localparam logic [7:0] OFF_MCLR = 8'h16;
  localparam logic [7:0] OFF_PEND = 8'h18;

  localparam logic [ADDR_W-1:0] SUMMARY_ADDR = 16'h0550;

  function automatic logic [ADDR_W-1:0] grp_base(input int g);
    case (g)
      0:       grp_base = 16'h0900;
      1:       grp_base = 16'h2400;
      2:       grp_base = 16'hC000;
      default: grp_base = 16'hC100;
    endcase
  endfunction

endpackage

// File: rtl/irq_agg_sync.sv
module irq_agg_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/irq_agg_detect.sv
module irq_agg_detect #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] edge_mode_i,
  input  logic [W-1:0] pol_hi_i,
  input  logic [W-1:0] pol_lo_i,
  output logic [W-1:0] hit_o
);

  logic [W-1:0] lvl_q;
  logic [W-1:0] rise, fall, edge_hit, level_hit;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= lvl_i;
  end

  always_comb begin
    rise      = lvl_i & ~lvl_q;
    fall      = ~lvl_i & lvl_q;
    edge_hit  = (rise & pol_hi_i) | (fall & pol_lo_i);
    level_hit = (lvl_i & pol_hi_i) | (~lvl_i & pol_lo_i);
    hit_o     = (edge_mode_i & edge_hit) | (~edge_mode_i & level_hit);
  end

endmodule

// File: rtl/irq_agg_bank.sv
module irq_agg_bank
  import irq_agg_pkg::*;
#(
  parameter int NS = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] lvl_i,
  input  logic              wr_i,
  input  logic [7:0]        off_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              pend_o
);

  localparam logic [DATA_W-1:0] IMPL = {DATA_W{1'b1}} >> (DATA_W - NS);

  logic [DATA_W-1:0] mode_q, polh_q, poll_q, en_q, latched_q;
  logic [DATA_W-1:0] wmask, ack_w, hit, raw;

  assign wmask = wdata_i & IMPL;
  assign raw   = lvl_i & IMPL;
  assign ack_w = (wr_i && off_i == OFF_ACK) ? wmask : '0;

  irq_agg_detect #(.W(DATA_W)) u_det (
    .clk         (clk),
    .rst         (rst),
    .lvl_i       (raw),
    .edge_mode_i (mode_q),
    .pol_hi_i    (polh_q),
    .pol_lo_i    (poll_q),
    .hit_o       (hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= '0;
      polh_q    <= '0;
      poll_q    <= '0;
      en_q      <= '0;
      latched_q <= '0;
    end else begin
      if (wr_i) begin
        case (off_i)
          OFF_MODE: mode_q <= wmask;
          OFF_POLH: polh_q <= wmask;
          OFF_POLL: poll_q <= wmask;
          OFF_MSET: en_q   <= en_q | wmask;
          OFF_MCLR: en_q   <= en_q & ~wmask;
          default: ;
        endcase
      end
      latched_q <= (latched_q | (hit & en_q)) & ~ack_w;
    end
  end

  always_comb begin
    case (off_i)
      OFF_RAW:  rd_data_o = raw;
      OFF_MODE: rd_data_o = mode_q;
      OFF_POLH: rd_data_o = polh_q;
      OFF_POLL: rd_data_o = poll_q;
      OFF_MSET: rd_data_o = en_q;
      OFF_MCLR: rd_data_o = en_q;
      OFF_PEND: rd_data_o = latched_q;
      default:  rd_data_o = '0;
    endcase
  end

  assign pend_o = |(latched_q & en_q);

  // R9
  masked_no_latch_chk: assert property (@(posedge clk) disable iff (rst)
    ((latched_q & ~$past(latched_q) & ~$past(en_q)) == '0));

  // R10
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_w != '0) |=> ((latched_q & $past(ack_w)) == '0));

  // R4
  mask_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_i && off_i == OFF_MSET) |=> ((en_q & $past(wmask)) == $past(wmask)));

  // R4
  mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_i && off_i == OFF_MCLR) |=> ((en_q & $past(wmask)) == '0));

endmodule

// File: rtl/irq_agg.sv
module irq_agg
  import irq_agg_pkg::*;
#(
  parameter int NUM_GROUPS  = 4,
  parameter int GRP0_SRCS   = 5,
  parameter int GRPN_SRCS   = 1,
  parameter int SYNC_STAGES = 2,
  localparam int SRC_TOTAL  = GRP0_SRCS + (NUM_GROUPS - 1) * GRPN_SRCS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SRC_TOTAL-1:0] src_i,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 irq_o
);

  logic [SRC_TOTAL-1:0]  lvl_s;
  logic [NUM_GROUPS-1:0] pend;
  logic [NUM_GROUPS-1:0] page_hit;
  logic [DATA_W-1:0]     bank_rd [NUM_GROUPS];
  logic [DATA_W-1:0]     summary;
  logic [DATA_W-1:0]     rd_next;

  irq_agg_sync #(.W(SRC_TOTAL), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (src_i),
    .q_o (lvl_s)
  );

  generate
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      localparam int NS = (g == 0) ? GRP0_SRCS : GRPN_SRCS;
      localparam int LO = (g == 0) ? 0 : GRP0_SRCS + (g - 1) * GRPN_SRCS;
      localparam logic [ADDR_W-1:0] BASE = grp_base(g);

      logic [DATA_W-1:0] lvl_ext;

      always_comb begin
        lvl_ext = '0;
        lvl_ext[NS-1:0] = lvl_s[LO +: NS];
      end

      assign page_hit[g] = (addr_i[ADDR_W-1:8] == BASE[ADDR_W-1:8]);

      irq_agg_bank #(.NS(NS)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .lvl_i     (lvl_ext),
        .wr_i      (wr_i & page_hit[g]),
        .off_i     (addr_i[7:0]),
        .wdata_i   (wdata_i),
        .rd_data_o (bank_rd[g]),
        .pend_o    (pend[g])
      );
    end
  endgenerate

  always_comb begin
    summary = '0;
    summary[NUM_GROUPS-1:0] = pend;
    rd_next = (addr_i == SUMMARY_ADDR) ? summary : '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (page_hit[g]) rd_next = rd_next | bank_rd[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      if (rd_i) rdata_o <= rd_next;
      irq_o <= |pend;
    end
  end

  // R12
  irq_rise_pending_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(|pend));

  // R12
  irq_fall_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_o) |-> !$past(|pend));

  // R11
  summary_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_i && addr_i == SUMMARY_ADDR) |=> (rdata_o[NUM_GROUPS-1:0] == $past(pend)));

  // R13
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(rdata_o));

endmodule

// File: tb/irq_agg_tb_top.sv
`timescale 1ns/1ps
module irq_agg_tb_top;

  localparam logic [7:0] OP_WR   = 8'd1;
  localparam logic [7:0] OP_RD   = 8'd2;
  localparam logic [7:0] OP_SRC  = 8'd3;
  localparam logic [7:0] OP_IRQ  = 8'd4;
  localparam logic [7:0] OP_WAIT = 8'd5;
  localparam int N = 65;

  // {op, addr, data, expected, requirement}
  localparam logic [47:0] TBL [N] = '{
    {OP_RD,  16'h0911, 8'h00, 8'h00, 8'd1},   // R1 mode reads 0
    {OP_RD,  16'h0550, 8'h00, 8'h00, 8'd1},   // R1 summary 0
    {OP_WR,  16'h0911, 8'hFF, 8'h00, 8'd2},
    {OP_RD,  16'h0911, 8'h00, 8'h1F, 8'd2},   // R2 only five bits
    {OP_WR,  16'h2411, 8'hFF, 8'h00, 8'd2},
    {OP_RD,  16'h2411, 8'h00, 8'h01, 8'd2},   // R2 one bit
    {OP_WR,  16'h0912, 8'h15, 8'h00, 8'd5},
    {OP_WR,  16'h0913, 8'h06, 8'h00, 8'd6},
    {OP_WR,  16'h0915, 8'h07, 8'h00, 8'd4},
    {OP_RD,  16'h0915, 8'h00, 8'h07, 8'd4},   // R4
    {OP_RD,  16'h0916, 8'h00, 8'h07, 8'd4},   // R4
    {OP_WR,  16'h0915, 8'h00, 8'h00, 8'd4},
    {OP_RD,  16'h0915, 8'h00, 8'h07, 8'd4},   // R4 zero write no effect
    {OP_SRC, 16'h0000, 8'h01, 8'h00, 8'd5},
    {OP_RD,  16'h0910, 8'h00, 8'h01, 8'd3},   // R3
    {OP_RD,  16'h0918, 8'h00, 8'h01, 8'd5},   // R5 rise latched
    {OP_IRQ, 16'h0000, 8'h00, 8'h01, 8'd12},  // R12
    {OP_RD,  16'h0550, 8'h00, 8'h01, 8'd11},  // R11
    {OP_WR,  16'h0914, 8'h01, 8'h00, 8'd10},
    {OP_RD,  16'h0918, 8'h00, 8'h00, 8'd10},  // R10
    {OP_IRQ, 16'h0000, 8'h00, 8'h00, 8'd12},  // R12
    {OP_SRC, 16'h0000, 8'h00, 8'h00, 8'd5},
    {OP_RD,  16'h0918, 8'h00, 8'h00, 8'd5},   // R5 fall ignored
    {OP_SRC, 16'h0000, 8'h02, 8'h00, 8'd6},
    {OP_RD,  16'h0918, 8'h00, 8'h00, 8'd6},   // R6 rise ignored
    {OP_SRC, 16'h0000, 8'h00, 8'h00, 8'd6},
    {OP_RD,  16'h0918, 8'h00, 8'h02, 8'd6},   // R6 fall latched
    {OP_WR,  16'h0914, 8'h02, 8'h00, 8'd10},
    {OP_SRC, 16'h0000, 8'h04, 8'h00, 8'd7},
    {OP_RD,  16'h0918, 8'h00, 8'h04, 8'd7},   // R7 rise
    {OP_WR,  16'h0914, 8'h04, 8'h00, 8'd7},
    {OP_SRC, 16'h0000, 8'h00, 8'h00, 8'd7},
    {OP_RD,  16'h0918, 8'h00, 8'h04, 8'd7},   // R7 fall
    {OP_WR,  16'h0914, 8'h04, 8'h00, 8'd7},
    {OP_SRC, 16'h0000, 8'h10, 8'h00, 8'd9},
    {OP_RD,  16'h0918, 8'h00, 8'h00, 8'd9},   // R9 masked
    {OP_RD,  16'h0910, 8'h00, 8'h10, 8'd3},   // R3 raw while masked
    {OP_IRQ, 16'h0000, 8'h00, 8'h00, 8'd9},   // R9
    {OP_SRC, 16'h0000, 8'h00, 8'h00, 8'd9},
    {OP_WR,  16'h2411, 8'h00, 8'h00, 8'd8},
    {OP_WR,  16'h2412, 8'h01, 8'h00, 8'd8},
    {OP_WR,  16'h2415, 8'h01, 8'h00, 8'd8},
    {OP_SRC, 16'h0000, 8'h20, 8'h00, 8'd8},
    {OP_RD,  16'h2418, 8'h00, 8'h01, 8'd8},   // R8 high level
    {OP_RD,  16'h0550, 8'h00, 8'h02, 8'd11},  // R11
    {OP_WR,  16'h2414, 8'h01, 8'h00, 8'd8},
    {OP_WAIT,16'h0000, 8'h00, 8'h00, 8'd8},
    {OP_RD,  16'h2418, 8'h00, 8'h01, 8'd8},   // R8 re-latch
    {OP_SRC, 16'h0000, 8'h00, 8'h00, 8'd8},
    {OP_WR,  16'h2414, 8'h01, 8'h00, 8'd8},
    {OP_RD,  16'h2418, 8'h00, 8'h00, 8'd8},   // R8 inactive stays clear
    {OP_WR,  16'hC013, 8'h01, 8'h00, 8'd8},
    {OP_WR,  16'hC015, 8'h01, 8'h00, 8'd8},
    {OP_WAIT,16'h0000, 8'h00, 8'h00, 8'd8},
    {OP_RD,  16'hC018, 8'h00, 8'h01, 8'd8},   // R8 low level
    {OP_RD,  16'h0550, 8'h00, 8'h04, 8'd11},  // R11
    {OP_SRC, 16'h0000, 8'h40, 8'h00, 8'd8},
    {OP_WR,  16'hC014, 8'h01, 8'h00, 8'd10},
    {OP_RD,  16'hC018, 8'h00, 8'h00, 8'd10},  // R10
    {OP_IRQ, 16'h0000, 8'h00, 8'h00, 8'd12},  // R12
    {OP_WR,  16'hC115, 8'h01, 8'h00, 8'd4},
    {OP_WR,  16'hC116, 8'h01, 8'h00, 8'd4},
    {OP_RD,  16'hC115, 8'h00, 8'h00, 8'd4},   // R4
    {OP_RD,  16'h1234, 8'h00, 8'h00, 8'd2},   // R2 unmapped
    {OP_RD,  16'h0917, 8'h00, 8'h00, 8'd2}    // R2 hole
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  src = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_agg dut_i (
    .clk (clk), .rst (rst), .src_i (src), .wr_i (wr), .rd_i (rd),
    .addr_i (addr), .wdata_i (wdata), .rdata_o (rdata), .irq_o (irq)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog expired act=%0d exp=<20000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d;
    tick(1);
    wr = 1'b0;
  endtask

  task automatic do_rd(input logic [15:0] a, input logic [7:0] exp, input int req);
    rd = 1'b1; addr = a;
    tick(1);
    rd = 1'b0;
    check(req, rdata, exp);
  endtask

  initial begin
    tick(3);
    check(1, {7'd0, irq}, 8'h00);   // R1 irq low in reset
    rst = 1'b0;
    tick(1);

    for (int i = 0; i < N; i++) begin
      case (TBL[i][47:40])
        OP_WR:   do_wr(TBL[i][39:24], TBL[i][23:16]);
        OP_RD:   do_rd(TBL[i][39:24], TBL[i][15:8], int'(TBL[i][7:0]));
        OP_SRC:  begin src = TBL[i][23:16]; tick(5); end
        OP_IRQ:  check(int'(TBL[i][7:0]), {7'd0, irq}, TBL[i][15:8]);
        default: tick(2);
      endcase
    end

    // R12 exact latency: pending on edge 3, irq on edge 4
    src = 8'h41;
    tick(3);
    check(12, {7'd0, irq}, 8'h00);
    tick(1);
    check(12, {7'd0, irq}, 8'h01);

    // R11 masking hides a pending bit but keeps it
    do_wr(16'h0916, 8'h01);
    do_rd(16'h0550, 8'h00, 11);
    do_rd(16'h0918, 8'h01, 11);
    check(11, {7'd0, irq}, 8'h00);
    do_wr(16'h0915, 8'h01);
    do_rd(16'h0550, 8'h01, 11);

    // R8 level re-latch leaves a one-cycle gap on irq (R12)
    do_wr(16'h0914, 8'h01);
    src = 8'h61;
    tick(5);
    check(8, {7'd0, irq}, 8'h01);
    do_wr(16'h2414, 8'h01);
    tick(1);
    check(8, {7'd0, irq}, 8'h00);
    tick(1);
    check(8, {7'd0, irq}, 8'h01);

    // R13 read data holds without a read
    do_rd(16'h2418, 8'h01, 13);
    tick(2);
    check(13, rdata, 8'h01);

    // R1 reset in mid-run
    rst = 1'b1;
    tick(2);
    rst = 1'b0;
    check(1, {7'd0, irq}, 8'h00);
    check(1, rdata, 8'h00);
    do_rd(16'h2415, 8'h00, 1);
    do_rd(16'h0911, 8'h00, 1);
    do_rd(16'h2418, 8'h00, 1);
    do_rd(16'h2410, 8'h01, 3);      // R3 raw after resync
    tick(4);
    check(1, {7'd0, irq}, 8'h00);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule